// File: doc/BRIEF.md
# PWM Output Emergency Shutdown Controller

This block sits between a motor-control PWM timer and six high-current output pads. It watches four active-low shutdown request lines and a compare between the timer's complementary outputs. When either source trips, the output enables of all six pads drop together in one clock. The pads then float until software walks through the release sequence for the source that caused the trip, or until a power-on reset.

Each request line is synchronized in two stages. The first stage samples on the falling clock edge and the second on the rising edge. The synchronized line then feeds a per-line detector, set to falling-edge or low-level mode. Every trip source keeps a sticky flag. A flag clears only through a read-then-write-zero rule on a small synchronous register bus. The flag for the output compare has two extra release guards: the compare must already be disabled, and all six timer outputs must be high. A combined interrupt request reports the flags that have their interrupt enable set.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: When any input flag or the output flag is 1, all six bits of `pwm_oe` are 0 in that same cycle. When every flag is 0, all six bits are 1. `pwm_out` always equals `pwm_in`.
- R2: In edge mode, an enabled request line that goes from 1 to 0 sets its flag. The flag becomes 1 at the second rising clock edge after the change, and not at the first.
- R3: In level mode (mode bit 1), an enabled request line held at 0 sets its flag again on every cycle. A clear attempted while the line is still 0 leaves the flag at 1.
- R4: A request line whose enable bit is 0 never sets its flag.
- R5: Output enables from an input trip come back only when all four input flags are 0. Clearing some of the flags keeps every pad disabled.
- R6: When the compare enable is 1 and any pin pair (0,1), (2,3) or (4,5) of `pwm_in` is 1 in both bits, the output flag is 1 from the next cycle.
- R7: A write of 0 to the output flag takes effect only if the compare enable was already 0 before that write. A single write that clears the enable and the flag together leaves the flag set.
- R8: A clear of the output flag takes effect only while `pwm_in` is 6'b111111. Otherwise the attempt is ignored.
- R9: A flag goes to 0 only when it was read as 1 and the very next write to its register carries 0 in its bit. Writing 1 leaves it unchanged. Writing 0 with no read since the last write leaves it unchanged.
- R10: `irq` is 1 exactly when (some input flag is 1 and the input interrupt enable is 1) or (the output flag is 1 and the output interrupt enable is 1).
- R11: Register map:
  - Address 0: bits [3:0] are the input flags; bit 4 is the input interrupt enable.
  - Address 1: bits [3:0] are the per-line detect enables; bits [7:4] are the per-line modes (0 = edge, 1 = level).
  - Address 2: bit 0 is the output flag; bit 1 is the compare enable; bit 2 is the output interrupt enable.
  - Address 3 reads 0. After reset, all registers read 0, `pwm_oe` is all ones and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| shdn_req_n | input | 4 | Shutdown request lines, idle high |
| pwm_in | input | 6 | Timer output levels; pairs (0,1), (2,3), (4,5) are complementary |
| pwm_out | output | 6 | Pad data, passed through from `pwm_in` |
| pwm_oe | output | 6 | Pad output enables; 0 puts the pad in high impedance |
| irq | output | 1 | Combined interrupt request |

## Verification
The case that is hardest to reach from the ports is releasing a compare trip. Software must disable the compare in one write, read the flag in a separate access, and then clear it while the timer drives all six pins high. The pin pattern that tripped the compare is exactly the kind that blocks the clear. The bench drives directed sequences that break each of these conditions one at a time. It then runs a random loop over timer patterns, and every pattern that trips the compare is followed by the full legal release.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int unsigned REQ_COUNT = 4;
  localparam int unsigned PIN_COUNT = 6;
  localparam int unsigned BUS_DW    = 16;
  localparam int unsigned BUS_AW    = 2;

  typedef enum logic [BUS_AW-1:0] {
    REG_IN_STAT  = 2'd0,
    REG_IN_CFG   = 2'd1,
    REG_OUT_STAT = 2'd2,
    REG_SPARE    = 2'd3
  } reg_addr_e;

  localparam int unsigned OUT_FLAG_BIT = 0;
  localparam int unsigned OUT_CMPEN_BIT = 1;
  localparam int unsigned OUT_IE_BIT = 2;

  function automatic logic addr_is(input logic [BUS_AW-1:0] a, input reg_addr_e r);
    return a == r;
  endfunction
endpackage

// File: rtl/psd_input_detect.sv
`timescale 1ns/1ps
module psd_input_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic en_i,
  input  logic level_mode_i,
  output logic hit_o
);
  logic stage_neg_q;
  logic sync_q;
  logic prev_q;

  // first stage on the falling edge of the base clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stage_neg_q <= 1'b1;
    else        stage_neg_q <= req_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= stage_neg_q;
      prev_q <= sync_q;
    end
  end

  logic fall_seen;
  logic low_seen;
  assign fall_seen = prev_q & ~sync_q;
  assign low_seen  = ~sync_q;
  assign hit_o     = en_i & (level_mode_i ? low_seen : fall_seen);
endmodule

// File: rtl/psd_out_compare.sv
`timescale 1ns/1ps
module psd_out_compare #(
  parameter int unsigned N_PIN = 6
) (
  input  logic [N_PIN-1:0] pins_i,
  input  logic             enable_i,
  output logic             trip_o,
  output logic             all_high_o
);
  localparam int unsigned N_PAIR = N_PIN / 2;
  logic [N_PAIR-1:0] pair_clash;

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    assign pair_clash[g] = pins_i[2*g] & pins_i[2*g+1];
  end

  assign trip_o     = enable_i & (|pair_clash);
  assign all_high_o = &pins_i;
endmodule

// File: rtl/psd_sticky_flag.sv
`timescale 1ns/1ps
module psd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic clr_ok_i,
  output logic flag_o,
  output logic clr_evt_o
);
  logic flag_q;
  logic armed_q;

  assign clr_evt_o = wr_i & ~wbit_i & armed_q & clr_ok_i;
  assign flag_o    = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)          flag_q <= 1'b1;
      else if (clr_evt_o) flag_q <= 1'b0;
      if (wr_i)                armed_q <= 1'b0;
      else if (rd_i && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_shutdown_ctrl.sv
`timescale 1ns/1ps
module pwm_shutdown_ctrl
  import psd_pkg::*;
#(
  parameter int unsigned N_REQ = REQ_COUNT,
  parameter int unsigned N_PIN = PIN_COUNT,
  parameter int unsigned DW    = BUS_DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [N_REQ-1:0]      shdn_req_n,
  input  logic [N_PIN-1:0]      pwm_in,
  output logic [N_PIN-1:0]      pwm_out,
  output logic [N_PIN-1:0]      pwm_oe,
  output logic                  irq
);
  localparam int unsigned IN_IE_BIT = N_REQ;
  localparam int unsigned MODE_LO   = N_REQ;
  localparam int unsigned MODE_HI   = 2 * N_REQ - 1;

  logic sel_in_stat, sel_in_cfg, sel_out_stat;
  assign sel_in_stat  = addr_is(bus_addr, REG_IN_STAT);
  assign sel_in_cfg   = addr_is(bus_addr, REG_IN_CFG);
  assign sel_out_stat = addr_is(bus_addr, REG_OUT_STAT);

  logic             in_ie_q, out_ie_q, oce_q;
  logic [N_REQ-1:0] det_en_q, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ie_q  <= 1'b0;
      out_ie_q <= 1'b0;
      oce_q    <= 1'b0;
      det_en_q <= '0;
      mode_q   <= '0;
    end else if (bus_wr) begin
      if (sel_in_stat) in_ie_q <= bus_wdata[IN_IE_BIT];
      if (sel_in_cfg) begin
        det_en_q <= bus_wdata[N_REQ-1:0];
        mode_q   <= bus_wdata[MODE_HI:MODE_LO];
      end
      if (sel_out_stat) begin
        oce_q    <= bus_wdata[OUT_CMPEN_BIT];
        out_ie_q <= bus_wdata[OUT_IE_BIT];
      end
    end
  end

  // input request detection and sticky flags
  logic [N_REQ-1:0] req_hit;
  logic [N_REQ-1:0] in_flag_q;
  logic [N_REQ-1:0] in_clr_evt;

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    psd_input_detect u_det (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_n_i      (shdn_req_n[i]),
      .en_i         (det_en_q[i]),
      .level_mode_i (mode_q[i]),
      .hit_o        (req_hit[i])
    );
    psd_sticky_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (req_hit[i]),
      .rd_i      (bus_rd & sel_in_stat),
      .wr_i      (bus_wr & sel_in_stat),
      .wbit_i    (bus_wdata[i]),
      .clr_ok_i  (1'b1),
      .flag_o    (in_flag_q[i]),
      .clr_evt_o (in_clr_evt[i])
    );
  end

  // output level compare and its flag
  logic cmp_trip, pins_all_high, osf_q, osf_clr_evt;

  psd_out_compare #(.N_PIN(N_PIN)) u_cmp (
    .pins_i     (pwm_in),
    .enable_i   (oce_q),
    .trip_o     (cmp_trip),
    .all_high_o (pins_all_high)
  );

  psd_sticky_flag u_osf (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (cmp_trip),
    .rd_i      (bus_rd & sel_out_stat),
    .wr_i      (bus_wr & sel_out_stat),
    .wbit_i    (bus_wdata[OUT_FLAG_BIT]),
    .clr_ok_i  (~oce_q & pins_all_high),
    .flag_o    (osf_q),
    .clr_evt_o (osf_clr_evt)
  );

  logic shutdown_any;
  assign shutdown_any = (|in_flag_q) | osf_q;
  assign pwm_oe  = {N_PIN{~shutdown_any}};
  assign pwm_out = pwm_in;
  assign irq     = (in_ie_q & (|in_flag_q)) | (out_ie_q & osf_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_IN_STAT: begin
        bus_rdata[N_REQ-1:0] = in_flag_q;
        bus_rdata[IN_IE_BIT] = in_ie_q;
      end
      REG_IN_CFG: begin
        bus_rdata[N_REQ-1:0]       = det_en_q;
        bus_rdata[MODE_HI:MODE_LO] = mode_q;
      end
      REG_OUT_STAT: begin
        bus_rdata[OUT_FLAG_BIT]  = osf_q;
        bus_rdata[OUT_CMPEN_BIT] = oce_q;
        bus_rdata[OUT_IE_BIT]    = out_ie_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DW-1:2*N_REQ], in_clr_evt, osf_clr_evt};
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned N_PIN = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] in_flag,
  input logic             osf,
  input logic             oce,
  input logic             trip,
  input logic [N_PIN-1:0] pwm_in,
  input logic [N_PIN-1:0] pwm_oe,
  input logic             bus_wr,
  input logic [1:0]       bus_addr
);
  // R1: any flag floats every pad together
  a_r1_flag_floats_all: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in_flag) || osf) |-> (pwm_oe == '0));

  // R1: enables never differ between pads
  a_r1_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe == '0) || (pwm_oe == '1));

  // R6: compare trip latches the output flag next cycle
  a_r6_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> osf);

  // R7: output flag only falls with compare already disabled
  a_r7_clear_needs_cmp_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osf) |-> !$past(oce));

  // R8: output flag only falls while every timer pin was high
  a_r8_clear_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osf) |-> (&$past(pwm_in)));

  // R9: an input flag only falls after a write to its register
  a_r9_in_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(in_flag) & ~in_flag)) |-> $past(bus_wr && bus_addr == 2'd0));
endmodule

bind pwm_shutdown_ctrl psd_checker #(.N_REQ(N_REQ), .N_PIN(N_PIN)) u_psd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_flag  (in_flag_q),
  .osf      (osf_q),
  .oce      (oce_q),
  .trip     (cmp_trip),
  .pwm_in   (pwm_in),
  .pwm_oe   (pwm_oe),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr)
);

// File: tb/pwm_shutdown_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_shutdown_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  shdn_req_n = 4'hF;
  logic [5:0]  pwm_in = '0;
  logic [5:0]  pwm_out;
  logic [5:0]  pwm_oe;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwm_shutdown_ctrl u_pwm_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shdn_req_n(shdn_req_n), .pwm_in(pwm_in), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .irq(irq)
  );

  function automatic bit ref_clash(input logic [5:0] p);
    bit hit = 1'b0;
    for (int k = 0; k < 6; k += 2) if (p[k] && p[k+1]) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [5:0] ref_oe(input bit floating);
    return floating ? 6'h00 : 6'h3F;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    tick(1);
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20250611));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11 reset state
    check("R11 oe", pwm_oe, 6'h3F);
    check("R11 irq", irq, 0);
    rd(2'd0, d); check("R11 reg0", d, 0);
    rd(2'd1, d); check("R11 reg1", d, 0);
    rd(2'd2, d); check("R11 reg2", d, 0);
    rd(2'd3, d); check("R11 reg3", d, 0);

    // R2 edge latency, R1 all pads together
    pwm_in = 6'b010101;
    wr(2'd1, 16'h000F);
    shdn_req_n[1] = 1'b0;
    tick(1); check("R2 not yet", pwm_oe, 6'h3F);
    tick(1); check("R2/R1 floated", pwm_oe, 6'h00);
    check("R1 pass-through", pwm_out, 6'b010101);
    shdn_req_n[1] = 1'b1;

    // R4 disabled line ignored
    wr(2'd1, 16'h000E);
    shdn_req_n[0] = 1'b0; tick(3); shdn_req_n[0] = 1'b1; tick(3);
    rd(2'd0, d); check("R4 disabled line", d[3:0], 4'h2);

    // R5 partial clear keeps pads floating, R9 rules
    shdn_req_n[2] = 1'b0; tick(3); shdn_req_n[2] = 1'b1; tick(2);
    rd(2'd0, d); check("R2 second flag", d[3:0], 4'h6);
    wr(2'd0, 16'h0004);
    rd(2'd0, d); check("R9 write one keeps", d[3:0], 4'h4);
    check("R5 subset cleared", pwm_oe, 6'h00);
    wr(2'd0, 16'h0004);
    wr(2'd0, 16'h0000);
    check("R9 no read no clear", pwm_oe, 6'h00);
    rd(2'd0, d);
    wr(2'd0, 16'h0000);
    check("R5 all cleared", pwm_oe, 6'h3F);
    rd(2'd0, d); check("R5 flags zero", d[3:0], 4'h0);

    // R3 level mode, R10 interrupt
    wr(2'd1, 16'h0088);
    shdn_req_n[3] = 1'b0; tick(3);
    check("R3 level sets", pwm_oe, 6'h00);
    check("R10 irq masked", irq, 0);
    rd(2'd0, d);
    wr(2'd0, 16'h0018);
    check("R10 irq enabled", irq, 1);
    rd(2'd0, d);
    wr(2'd0, 16'h0010);
    check("R3 held low resets", pwm_oe, 6'h00);
    shdn_req_n[3] = 1'b1; tick(3);
    rd(2'd0, d);
    wr(2'd0, 16'h0010);
    check("R3 cleared after high", pwm_oe, 6'h3F);
    check("R10 irq drops", irq, 0);
    wr(2'd0, 16'h0000);

    // R6 compare trip, R7 and R8 release guards
    pwm_in = 6'b000000;
    wr(2'd2, 16'h0002);
    pwm_in = 6'b000011;
    tick(1); check("R6 trip floats", pwm_oe, 6'h00);
    check("R10 out irq masked", irq, 0);
    wr(2'd2, 16'h0006);
    check("R10 out irq", irq, 1);
    rd(2'd2, d);
    wr(2'd2, 16'h0006);
    rd(2'd2, d); check("R7 cmp still on", d[0], 1);
    wr(2'd2, 16'h0004);
    check("R7 same write ignored", pwm_oe, 6'h00);
    pwm_in = 6'b111110;
    rd(2'd2, d);
    wr(2'd2, 16'h0004);
    check("R8 not all high", pwm_oe, 6'h00);
    pwm_in = 6'b111111;
    rd(2'd2, d);
    wr(2'd2, 16'h0004);
    check("R8 all high clears", pwm_oe, 6'h3F);
    check("R10 out irq drops", irq, 0);

    // R6 random timer patterns
    pwm_in = 6'b000000;
    wr(2'd2, 16'h0002);
    for (int it = 0; it < 40; it++) begin
      logic [5:0] p;
      bit exp_hit;
      p = 6'($urandom);
      exp_hit = ref_clash(p);
      pwm_in = p;
      tick(1);
      check("R6 random", pwm_oe, ref_oe(exp_hit));
      if (exp_hit) begin
        pwm_in = 6'h3F;
        rd(2'd2, d); wr(2'd2, 16'h0000);
        rd(2'd2, d); wr(2'd2, 16'h0000);
        check("R7 random release", pwm_oe, 6'h3F);
      end
      pwm_in = 6'b000000;
      wr(2'd2, 16'h0002);
    end
    wr(2'd2, 16'h0000);

    // R2 random request masks
    wr(2'd1, 16'h000F);
    for (int it = 0; it < 40; it++) begin
      logic [3:0] m;
      m = 4'($urandom);
      shdn_req_n = ~m; tick(3);
      shdn_req_n = 4'hF; tick(3);
      check("R1 random floating", pwm_oe, ref_oe(m != 0));
      rd(2'd0, d); check("R2 random flags", d[3:0], m);
      wr(2'd0, 16'h0000);
      check("R9 random clear", pwm_oe, 6'h3F);
    end

    summary();
  end
endmodule